// File: doc/BRIEF.md
# Dual-Output Power Stage PWM Generator

This block drives one leg of a power stage with two pulse-width modulated outputs, A and B. A 12-bit counter runs freely between zero and a programmable top value. One full waveform cycle is made of two sub-cycles that follow each other: output A can only be active during the first, and output B only during the second. Each output has its own turn-on and turn-off compare value. Three copies of the block side by side give the six signals a three-phase motor bridge needs.

The counter has two counting modes. In single-ramp mode each sub-cycle is a full count from zero to top. In centered mode the first sub-cycle counts up and the second counts back down, so the pulses are placed symmetrically. Every setting is written into a holding copy. The holding copies are moved into the working copies only at the end of a full cycle, which the block marks with a one-clock pulse. A fault input blanks both outputs at once. The blanking is latched and is lifted only after the fault has gone, a clear request has arrived, and the next full cycle has begun.

Top module: `pwm_leg_gen`

## Requirements
- R1: While reset is asserted and right after it, both outputs and the cycle-end pulse are low, and every working setting is zero.
- R2: In single-ramp mode (mode register bit 0 = 0) with top T, the counter goes 0..T during sub-cycle A and 0..T again during sub-cycle B, so a full cycle lasts 2(T+1) clocks.
- R3: In centered mode (mode register bit 0 = 1), the counter goes 0..T during sub-cycle A and T down to 0 during sub-cycle B, again 2(T+1) clocks per cycle.
- R4: Output A is high only during sub-cycle A, and only while its turn-on value <= counter < its turn-off value.
- R5: Output B is high only during sub-cycle B, and only while its turn-on value <= counter < its turn-off value.
- R6: Writes go to holding registers selected by address (0 top, 1 A turn-on, 2 A turn-off, 3 B turn-on, 4 B turn-off, 5 mode; other addresses are ignored). `upd_pulse` is high during the last clock of sub-cycle B. On that clock edge the holding values written before that clock become the working values, and the counter restarts sub-cycle A at 0.
- R7: While `fault_in` is high, both outputs are low in the same clock, whatever the counter phase.
- R8: A fault is latched. `fault_clr` has no effect while `fault_in` is still high. After a clear with `fault_in` low, the outputs stay low until the next cycle end, and normal waveforms resume with the next cycle.
- R9: With a working top of 0 both outputs stay low and the counter stays at 0.
- R10: While `en` is low the counter is held at 0 in sub-cycle A, the outputs are low, and the holding values are copied into the working values on every clock, so a new run starts at the beginning of a cycle with the latest settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable for the counter and outputs |
| wr_en | input | 1 | Write strobe for a holding register |
| wr_addr | input | 3 | Holding register select |
| wr_data | input | 12 | Write data (mode uses bit 0) |
| fault_in | input | 1 | Fault request; blanks both outputs at once |
| fault_clr | input | 1 | Request to lift a latched fault |
| out_a | output | 1 | PWM output of sub-cycle A |
| out_b | output | 1 | PWM output of sub-cycle B |
| upd_pulse | output | 1 | High on the last clock of each full cycle |

## Verification
The hardest situation to reach from the ports is a register write that lands on the very clock that ends a cycle. That write must miss the update that is happening and take effect one full cycle later. A fault clear that arrives partway through a cycle must also hold the outputs low for the rest of that cycle. The bench runs a cycle-accurate model of the cycle position, the holding and working settings and the fault state. It steps this model once per clock, waits until the model's position is the final clock of sub-cycle B, and writes there. Likewise it raises, holds, clears early and clears late the fault at positions chosen by the model. A near-exhaustive sweep then covers every top value from 0 to 4, every compare placement and both modes.

// File: rtl/pwm_leg_pkg.sv
package pwm_leg_pkg;

  parameter int unsigned PWM_CNT_W  = 12;
  parameter int unsigned PWM_ADDR_W = 3;

  typedef logic [PWM_CNT_W-1:0]  cnt_t;
  typedef logic [PWM_ADDR_W-1:0] addr_t;

  typedef enum logic [PWM_ADDR_W-1:0] {
    ADDR_TOP   = 3'd0,
    ADDR_A_ON  = 3'd1,
    ADDR_A_OFF = 3'd2,
    ADDR_B_ON  = 3'd3,
    ADDR_B_OFF = 3'd4,
    ADDR_MODE  = 3'd5
  } reg_addr_e;

  typedef enum logic [1:0] {
    BLK_RUN   = 2'd0,
    BLK_HELD  = 2'd1,
    BLK_REARM = 2'd2
  } blank_e;

  typedef struct packed {
    cnt_t top;
    cnt_t a_on;
    cnt_t a_off;
    cnt_t b_on;
    cnt_t b_off;
    logic centered;
  } leg_cfg_t;

  // Half-open compare window [on, off)
  function automatic logic in_window(cnt_t c, cnt_t on, cnt_t off);
    return (c >= on) && (c < off);
  endfunction

  // Final clock of the current sub-cycle
  function automatic logic is_last_tick(cnt_t c, cnt_t top, logic ph_b, logic centered);
    if (ph_b && centered) return c == '0;
    return c == top;
  endfunction

  // Counter value for the next clock when the cycle does not end here
  function automatic cnt_t step_cnt(cnt_t c, cnt_t top, logic ph_b, logic centered);
    if (!ph_b) begin
      if (c == top) return centered ? c : '0;
      return c + cnt_t'(1);
    end
    if (centered) return c - cnt_t'(1);
    return c + cnt_t'(1);
  endfunction

endpackage

// File: rtl/pwm_leg_regs.sv
module pwm_leg_regs
  import pwm_leg_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     cyc_end,
  input  logic     wr_en,
  input  addr_t    wr_addr,
  input  cnt_t     wr_data,
  output leg_cfg_t act_cfg
);

  leg_cfg_t hold_cfg;
  logic     load_act;

  assign load_act = !en || cyc_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cfg <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_TOP:   hold_cfg.top      <= wr_data;
        ADDR_A_ON:  hold_cfg.a_on     <= wr_data;
        ADDR_A_OFF: hold_cfg.a_off    <= wr_data;
        ADDR_B_ON:  hold_cfg.b_on     <= wr_data;
        ADDR_B_OFF: hold_cfg.b_off    <= wr_data;
        ADDR_MODE:  hold_cfg.centered <= wr_data[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        act_cfg <= '0;
    else if (load_act) act_cfg <= hold_cfg;
  end

  // R6
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !cyc_end) |=> $stable(act_cfg));

  // R10
  act_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !wr_en && $stable(hold_cfg)) |=> (act_cfg == hold_cfg));

endmodule

// File: rtl/pwm_leg_counter.sv
module pwm_leg_counter
  import pwm_leg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  cnt_t top,
  input  logic centered,
  output cnt_t cnt,
  output logic ph_b,
  output logic cyc_end
);

  logic last_tick;

  assign last_tick = is_last_tick(cnt, top, ph_b, centered);
  assign cyc_end   = en && ph_b && last_tick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt  <= '0;
      ph_b <= 1'b0;
    end else if (!en || cyc_end) begin
      cnt  <= '0;
      ph_b <= 1'b0;
    end else begin
      if (!ph_b && last_tick) ph_b <= 1'b1;
      cnt <= step_cnt(cnt, top, ph_b, centered);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= top);

  // R2
  ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !centered && !last_tick) |=> (cnt == $past(cnt) + cnt_t'(1)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && centered && ph_b && !last_tick) |=> (cnt == $past(cnt) - cnt_t'(1)));

  // R6
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_end |=> (cnt == '0 && !ph_b));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0 && !ph_b));

endmodule

// File: rtl/pwm_leg_fault.sv
module pwm_leg_fault
  import pwm_leg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic cyc_end,
  input  logic fault_in,
  input  logic fault_clr,
  output logic blank
);

  blank_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= BLK_RUN;
    end else if (fault_in) begin
      st <= BLK_HELD;
    end else begin
      case (st)
        BLK_HELD:  if (fault_clr) st <= BLK_REARM;
        BLK_REARM: if (cyc_end || !en) st <= BLK_RUN;
        default:   st <= BLK_RUN;
      endcase
    end
  end

  assign blank = fault_in || (st != BLK_RUN);

  // R8
  held_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BLK_HELD && !fault_clr) |=> (st == BLK_HELD));

  // R8
  rearm_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == BLK_REARM && !fault_in && en && !cyc_end) |=> (st == BLK_REARM));

endmodule

// File: rtl/pwm_leg_gen.sv
module pwm_leg_gen
  import pwm_leg_pkg::*;
#(
  parameter int unsigned CNT_W  = PWM_CNT_W,
  parameter int unsigned ADDR_W = PWM_ADDR_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data,
  input  logic              fault_in,
  input  logic              fault_clr,
  output logic              out_a,
  output logic              out_b,
  output logic              upd_pulse
);

  localparam int unsigned N_OUT = 2;

  leg_cfg_t   act_cfg;
  cnt_t       cnt;
  logic       ph_b;
  logic       cyc_end;
  logic       blank;
  logic       run_ok;
  cnt_t       on_v  [N_OUT];
  cnt_t       off_v [N_OUT];
  logic [N_OUT-1:0] raw_win;

  pwm_leg_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en),
    .cyc_end (cyc_end),
    .wr_en   (wr_en),
    .wr_addr (addr_t'(wr_addr)),
    .wr_data (cnt_t'(wr_data)),
    .act_cfg (act_cfg)
  );

  pwm_leg_counter u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .top      (act_cfg.top),
    .centered (act_cfg.centered),
    .cnt      (cnt),
    .ph_b     (ph_b),
    .cyc_end  (cyc_end)
  );

  pwm_leg_fault u_flt (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .cyc_end   (cyc_end),
    .fault_in  (fault_in),
    .fault_clr (fault_clr),
    .blank     (blank)
  );

  assign on_v[0]  = act_cfg.a_on;
  assign off_v[0] = act_cfg.a_off;
  assign on_v[1]  = act_cfg.b_on;
  assign off_v[1] = act_cfg.b_off;

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_win
      assign raw_win[g] = (ph_b == (g == 1)) && in_window(cnt, on_v[g], off_v[g]);
    end
  endgenerate

  assign run_ok    = en && (act_cfg.top != '0) && !blank;
  assign out_a     = raw_win[0] && run_ok;
  assign out_b     = raw_win[1] && run_ok;
  assign upd_pulse = cyc_end;

  // R4
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_b));

  // R7
  fault_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_in |=> (!out_a && !out_b));

  // R9
  zero_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg.top == '0) |-> (!out_a && !out_b && cnt == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (act_cfg == '0 && cnt == '0));

endmodule

// File: tb/pwm_leg_gen_tb.sv
`timescale 1ns/1ps
module pwm_leg_gen_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        fault_in = 1'b0;
  logic        fault_clr = 1'b0;
  logic        out_a, out_b, upd_pulse;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  int sh  [6];
  int act [6];
  int st_m = 0;   // 0 run, 1 held, 2 rearm
  int k = 0;

  always #10 clk = ~clk;

  pwm_leg_gen u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .fault_in(fault_in), .fault_clr(fault_clr),
    .out_a(out_a), .out_b(out_b), .upd_pulse(upd_pulse)
  );

  task automatic check(string tag, string what, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b (k=%0d)", tag, what, got, exp, k);
    end
  endtask

  // One clock of model and comparison; called right after a falling edge
  task automatic tick(string tag);
    int  t, p, c;
    bit  pb, blank_m, ea, eb, eu, eoc;
    #1;
    t = act[0];
    p = 2 * (t + 1);
    if (!en) begin c = 0; pb = 0; end
    else begin
      pb = (k > t);
      if (!pb) c = k;
      else c = (act[5] != 0) ? (2 * t + 1 - k) : (k - t - 1);
    end
    blank_m = fault_in || (st_m != 0);
    ea = en && (t != 0) && !pb && (c >= act[1]) && (c < act[2]) && !blank_m;
    eb = en && (t != 0) &&  pb && (c >= act[3]) && (c < act[4]) && !blank_m;
    eu = en && (k == p - 1);
    check({tag, "/R4"}, "out_a", out_a, ea);
    check({tag, "/R5"}, "out_b", out_b, eb);
    check({tag, "/R6"}, "upd_pulse", upd_pulse, eu);
    eoc = eu;
    if (!en || eoc) for (int i = 0; i < 6; i++) act[i] = sh[i];
    if (wr_en && wr_addr < 3'd6) sh[wr_addr] = (wr_addr == 3'd5) ? int'(wr_data[0]) : int'(wr_data);
    if (fault_in) st_m = 1;
    else if (st_m == 1 && fault_clr) st_m = 2;
    else if (st_m == 2 && (eoc || !en)) st_m = 0;
    if (!en || eoc) k = 0; else k = k + 1;
    @(negedge clk);
  endtask

  task automatic write_reg(int a, int d, string tag);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 12'(d);
    tick(tag);
    wr_en = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  task automatic setup(int t, int m, int aon, int aoff, int bon, int boff, string tag);
    en = 1'b0;
    write_reg(0, t, tag);    write_reg(1, aon, tag);
    write_reg(2, aoff, tag); write_reg(3, bon, tag);
    write_reg(4, boff, tag); write_reg(5, m, tag);
    tick(tag);
    en = 1'b1;
  endtask

  initial begin
    #(20.0 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin sh[i] = 0; act[i] = 0; end
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check("R1", "out_a", out_a, 1'b0);
    check("R1", "out_b", out_b, 1'b0);
    check("R1", "upd_pulse", upd_pulse, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    en = 1'b1;
    run(4, "R1");       // zero top right after reset: quiet, cycle every 2 clocks

    // Sweep: both modes, small tops, every compare placement (R2 R3 R9)
    for (int m = 0; m < 2; m++)
      for (int t = 0; t <= 4; t++)
        for (int aon = 0; aon <= t + 1; aon++)
          for (int aoff = 0; aoff <= t + 1; aoff++) begin
            setup(t, m, aon, aoff, (aon + 1) % (t + 2), (aoff + t) % (t + 2), "R10");
            run(4 * (t + 1) + 2, (t == 0) ? "R9" : (m != 0) ? "R3" : "R2");
          end

    // R6 writes mid-cycle take effect at the next cycle only
    setup(3, 0, 0, 2, 1, 3, "R6");
    run(3, "R6");
    write_reg(0, 6, "R6");
    write_reg(2, 5, "R6");
    run(20, "R6");
    // R6 write on the cycle-end clock misses that update
    while (k != 2 * (act[0] + 1) - 1) tick("R6");
    write_reg(5, 1, "R6");
    write_reg(4, 7, "R6");
    run(40, "R6");
    // R6 out-of-map address is ignored
    write_reg(7, 1, "R6");
    run(30, "R6");

    // R7 R8 fault handling
    setup(4, 0, 0, 5, 0, 5, "R7");
    run(3, "R7");
    fault_in = 1'b1;
    run(4, "R7");
    fault_clr = 1'b1;
    tick("R8");          // clear while fault still present: ignored
    fault_clr = 1'b0;
    fault_in = 1'b0;
    run(12, "R8");       // still held across a cycle end
    run(3, "R8");
    fault_clr = 1'b1;
    tick("R8");
    fault_clr = 1'b0;
    run(25, "R8");       // low until next cycle start, then normal
    setup(4, 1, 1, 4, 0, 3, "R7");
    run(6, "R7");
    fault_in = 1'b1;
    tick("R7");
    fault_in = 1'b0;
    fault_clr = 1'b1;
    tick("R8");
    fault_clr = 1'b0;
    run(25, "R8");

    // R10 disable mid-cycle then resume from cycle start
    setup(5, 0, 1, 4, 2, 6, "R10");
    run(7, "R10");
    en = 1'b0;
    write_reg(0, 3, "R10");
    run(2, "R10");
    en = 1'b1;
    run(20, "R10");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule